// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block collects interrupt requests for a CPU and hands over one at a time. The sources are one non-maskable line, a set of external request pins and a set of internal peripheral request lines. Each of the two maskable groups has a per-source enable bit. All maskable sources are also gated by a global mask bit taken from the CPU condition-code register. The non-maskable line is never affected by that mask.

Among the accepted requests, the block selects the one with the highest priority. It presents a request flag and the vector number of that request on registered outputs. The vector stays frozen while the flag is high, so the CPU can take it when it acknowledges. An acknowledge pulse clears the latched request that was presented. Requests that lost, or that were held back by the mask, remain pending and compete again on the next selection.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_out` is 0 and `vec_out` is 0, and no request is pending.
- R2: A falling edge on an external pin `ext_irq_n[i]` is latched as pending only if `ext_en[i]` is 1. An edge that arrives while the enable is 0 is discarded and is not presented after the enable is later set.
- R3: While `i_mask` is 1, no maskable source is presented. Maskable requests that are pending stay pending and are presented once `i_mask` returns to 0.
- R4: A rising edge on `nmi_in` is latched. It is presented with vector 3 whatever the value of `i_mask`, and it outranks every maskable source.
- R5: Among accepted maskable sources, the lowest index wins. Every external pin ranks above every internal source.
- R6: While `irq_out` is 1 and `ack` is 0, `irq_out` and `vec_out` hold their values, even if a higher-priority request arrives.
- R7: `ack` while `irq_out` is 1 drives `irq_out` to 0 on the next cycle and clears the latched request of the presented source. The remaining requests are presented one cycle after that.
- R8: An internal source is a level request, accepted while `int_req[j]` and `int_en[j]` are both 1. `ack` does not clear it, so if it is still high it is presented again.
- R9: Vector numbers are 3 for the non-maskable line, 4+i for external pin i, and 4+N_EXT+j for internal source j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge triggered |
| ext_irq_n | input | N_EXT | External request pins, falling-edge triggered, idle high |
| ext_en | input | N_EXT | Per-pin enable |
| int_req | input | N_INT | Internal peripheral request levels |
| int_en | input | N_INT | Per-peripheral enable |
| i_mask | input | 1 | Global mask bit from the CPU; 1 blocks all maskable sources |
| ack | input | 1 | CPU acknowledge of the presented request, one-cycle pulse |
| irq_out | output | 1 | Request flag to the CPU, registered |
| vec_out | output | VEC_W | Vector number of the presented request, registered |

## Verification
The hardest condition to reach from the ports is two sources that are accepted in the same cycle. External pins become pending one cycle later than internal levels, so raising both at once lets whichever arrives first lock the output. The stimulus therefore raises each pair of sources while `i_mask` is 1, waits until both are pending, and then clears the mask. This makes the pair compete in a single selection. Every pair of the twelve maskable sources is swept this way, checking the winner, the gap after acknowledge and the loser. Directed cases then cover the frozen vector, a non-maskable request under the mask, and edges discarded while a pin is disabled.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NMI_VEC  = 3;
  localparam int EXT_BASE = 4;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int W      = 8,
  parameter bit RISING = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] arm,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  localparam logic IDLE = RISING ? 1'b0 : 1'b1;

  logic [W-1:0] prev;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic hit;
    if (RISING) begin : g_rise
      assign hit = sig[g] & ~prev[g];
    end else begin : g_fall
      assign hit = ~sig[g] & prev[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[g] <= IDLE;
        pend[g] <= 1'b0;
      end else begin
        prev[g] <= sig[g];
        if (hit && arm[g])
          pend[g] <= 1'b1;
        else if (clr[g])
          pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N    = 12,
  parameter int VW   = 4,
  parameter int BASE = 4
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [VW-1:0] vec
);
  always_comb begin
    hit = |req;
    vec = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) vec = VW'(BASE + k);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_EXT = 8,
  parameter int N_INT = 4,
  parameter int VEC_W = $clog2(EXT_BASE + N_EXT + N_INT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_in,
  input  logic [N_EXT-1:0] ext_irq_n,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_INT-1:0] int_en,
  input  logic             i_mask,
  input  logic             ack,
  output logic             irq_out,
  output logic [VEC_W-1:0] vec_out
);
  localparam int N_MSK = N_EXT + N_INT;
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

  logic             ack_fire;
  logic             nmi_pend;
  logic             nmi_clr;
  logic [N_EXT-1:0] ext_pend;
  logic [N_EXT-1:0] ext_clr;
  logic [N_MSK-1:0] acc;
  logic             msk_hit;
  logic [VEC_W-1:0] msk_vec;
  logic             win_hit;
  logic [VEC_W-1:0] win_vec;

  assign ack_fire = ack & irq_out;
  assign nmi_clr  = ack_fire && (vec_out == NMI_V);

  for (genvar g = 0; g < N_EXT; g++) begin : g_clr
    localparam logic [VEC_W-1:0] MYV = VEC_W'(EXT_BASE + g);
    assign ext_clr[g] = ack_fire && (vec_out == MYV);
  end

  irq_edge_latch #(.W(1), .RISING(1'b1)) u_nmi (
    .clk (clk),
    .rst (rst),
    .sig (nmi_in),
    .arm (1'b1),
    .clr (nmi_clr),
    .pend(nmi_pend)
  );

  irq_edge_latch #(.W(N_EXT), .RISING(1'b0)) u_ext (
    .clk (clk),
    .rst (rst),
    .sig (ext_irq_n),
    .arm (ext_en),
    .clr (ext_clr),
    .pend(ext_pend)
  );

  assign acc = {int_req & int_en, ext_pend & ext_en} & {N_MSK{~i_mask}};

  irq_prio_pick #(.N(N_MSK), .VW(VEC_W), .BASE(EXT_BASE)) u_pick (
    .req(acc),
    .hit(msk_hit),
    .vec(msk_vec)
  );

  assign win_hit = nmi_pend | msk_hit;
  assign win_vec = nmi_pend ? NMI_V : msk_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      vec_out <= '0;
    end else if (irq_out) begin
      if (ack) irq_out <= 1'b0;
    end else if (win_hit) begin
      irq_out <= 1'b1;
      vec_out <= win_vec;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N_EXT = 8,
  parameter int N_INT = 4,
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             i_mask,
  input logic             ack,
  input logic             irq_out,
  input logic [VEC_W-1:0] vec_out
);
  localparam int VMAX = 4 + N_EXT + N_INT;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!irq_out && vec_out == '0));

  assert_masked_nmi_only_R3: assert property (@(posedge clk) disable iff (rst)
    (!irq_out && i_mask) |=> (!irq_out || vec_out == VEC_W'(3)));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack) |=> (irq_out && $stable(vec_out)));

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_out && ack) |=> !irq_out);

  assert_vec_range_R9: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (vec_out >= VEC_W'(3) && 32'(vec_out) < VMAX));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N_EXT(N_EXT), .N_INT(N_INT), .VEC_W(VEC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .i_mask (i_mask),
  .ack    (ack),
  .irq_out(irq_out),
  .vec_out(vec_out)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int NE = 8;
  localparam int NI = 4;
  localparam int VW = 4;
  localparam int NM = NE + NI;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          nmi_in = 1'b0;
  logic [NE-1:0] ext_irq_n = '1;
  logic [NE-1:0] ext_en = '1;
  logic [NI-1:0] int_req = '0;
  logic [NI-1:0] int_en = '1;
  logic          i_mask = 1'b0;
  logic          ack = 1'b0;
  logic          irq_out;
  logic [VW-1:0] vec_out;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.N_EXT(NE), .N_INT(NI), .VEC_W(VW)) u0 (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .ext_irq_n(ext_irq_n),
    .ext_en(ext_en), .int_req(int_req), .int_en(int_en),
    .i_mask(i_mask), .ack(ack), .irq_out(irq_out), .vec_out(vec_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int vexp(input int k);
    return 4 + k;
  endfunction

  task automatic src(input int k, input bit on);
    if (k < NE) ext_irq_n[k] = ~on;
    else int_req[k-NE] = on;
  endtask

  task automatic do_ack(input int k);
    ack = 1'b1;
    if (k >= NE) int_req[k-NE] = 1'b0;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL R7 watchdog: cycles=%0d expected<=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    chk("R1 irq", int'(irq_out), 0);
    chk("R1 vec", int'(vec_out), 0);
    rst = 1'b0;
    tick(3);
    chk("R1 nothing pending", int'(irq_out), 0);

    for (int k = 0; k < NM; k++) begin
      src(k, 1'b1);
      tick(2);
      chk("R2/R9 single", int'(irq_out), 1);
      chk("R9 single vec", int'(vec_out), vexp(k));
      do_ack(k);
      chk("R7 single ack", int'(irq_out), 0);
      src(k, 1'b0);
      tick(2);
      chk("R7 cleared", int'(irq_out), 0);
    end

    for (int a = 0; a < NM; a++) begin
      for (int b = a + 1; b < NM; b++) begin
        i_mask = 1'b1;
        src(a, 1'b1);
        src(b, 1'b1);
        tick(2);
        chk("R3 masked", int'(irq_out), 0);
        i_mask = 1'b0;
        tick(1);
        chk("R5 winner", int'(vec_out), vexp(a));
        do_ack(a);
        chk("R7 gap", int'(irq_out), 0);
        tick(1);
        chk("R5 loser", int'(irq_out) * 100 + int'(vec_out), 100 + vexp(b));
        do_ack(b);
        ext_irq_n = '1;
        tick(1);
        chk("R7 drained", int'(irq_out), 0);
      end
    end

    ext_en[2] = 1'b0;
    ext_irq_n[2] = 1'b0;
    tick(3);
    chk("R2 disabled edge", int'(irq_out), 0);
    ext_en[2] = 1'b1;
    tick(3);
    chk("R2 edge discarded", int'(irq_out), 0);
    ext_irq_n[2] = 1'b1;
    int_en[1] = 1'b0;
    int_req[1] = 1'b1;
    tick(3);
    chk("R8 disabled level", int'(irq_out), 0);
    int_req[1] = 1'b0;
    int_en[1] = 1'b1;
    tick(1);

    i_mask = 1'b1;
    ext_irq_n[0] = 1'b0;
    tick(1);
    nmi_in = 1'b1;
    tick(2);
    chk("R4 nmi under mask", int'(irq_out) * 100 + int'(vec_out), 103);
    nmi_in = 1'b0;
    do_ack(0);
    chk("R7 nmi ack", int'(irq_out), 0);
    tick(2);
    chk("R3 ext held", int'(irq_out), 0);
    i_mask = 1'b0;
    tick(1);
    chk("R3 released", int'(vec_out), 4);
    do_ack(0);
    ext_irq_n[0] = 1'b1;
    tick(1);

    ext_irq_n[5] = 1'b0;
    nmi_in = 1'b1;
    tick(2);
    chk("R4 nmi outranks", int'(vec_out), 3);
    nmi_in = 1'b0;
    do_ack(0);
    tick(1);
    chk("R4 then ext", int'(vec_out), 9);
    do_ack(5);
    ext_irq_n[5] = 1'b1;
    tick(1);

    int_req[3] = 1'b1;
    tick(1);
    chk("R6 first", int'(vec_out), 15);
    ext_irq_n[0] = 1'b0;
    tick(3);
    chk("R6 held vec", int'(irq_out) * 100 + int'(vec_out), 115);
    do_ack(NE + 3);
    tick(1);
    chk("R6 after release", int'(vec_out), 4);
    do_ack(0);
    ext_irq_n[0] = 1'b1;
    tick(1);

    int_req[1] = 1'b1;
    tick(1);
    chk("R8 level", int'(vec_out), 13);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk("R8 ack gap", int'(irq_out), 0);
    tick(1);
    chk("R8 re-presented", int'(irq_out) * 100 + int'(vec_out), 113);
    do_ack(NE + 1);
    tick(2);
    chk("R8 gone", int'(irq_out), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule